// File: doc/BRIEF.md
# Read-Cleared Interrupt Aggregator

This block gathers single-cycle event pulses from a fixed set of sources and holds them in a pending register. Typical sources are receive almost-full, transmit almost-empty, packet lock-out and overflow. A per-source enable mask and one global enable decide whether each event is captured at all. Events from a disabled source are dropped and never recorded.

A single registered, active-high interrupt line goes to the host. It is high whenever an enabled flag is pending. It falls only after the host reads the pending register, and that read empties the register in one cycle.

The host writes the two enable registers over a small write port, one address bit wide. It reads the pending register with a one-cycle read strobe. The read result is registered and is held until the next read.

Top module: `irq_aggregator`

## Requirements
- R1: During and after synchronous reset, the interrupt line, the read data, every pending flag, the source mask and the global enable are all 0.
- R2: An event pulse on source i is latched into the pending register at the clock edge that samples it, provided mask bit i and the global enable are both 1 at that edge. The interrupt line is high after that same edge.
- R3: An event on a source whose mask bit is 0 is not latched. Setting the mask bit afterwards neither raises the interrupt line nor makes the flag readable.
- R4: While the global enable is 0, no event on any source is latched, whatever the mask holds.
- R5: With no read, pending flags accumulate. Each enabled event sets its bit, and no bit clears.
- R6: A read strobe loads the read data with the pending flags ANDed with the current effective enables (bit i at position i, unused upper bits 0). The same edge clears every pending flag, so the interrupt line is low after it unless R7 applies.
- R7: An enabled event arriving in the same cycle as a read is not lost. It is absent from that read's data, remains pending, and keeps the interrupt line high after the edge.
- R8: Clearing a source's mask bit, or the global enable, takes its pending flag out of the interrupt line at the write edge without erasing it. Re-enabling brings the line back, and a later read returns the flag.
- R9: Once high, the interrupt line stays high until a read strobe or an enable write.
- R10: A write with address 0 loads the source mask from write data bits [N_SRC-1:0]. A write with address 1 loads the global enable from write data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | Event pulses, one bit per source |
| wr_en_i | input | 1 | Enable-register write strobe |
| wr_addr_i | input | 1 | 0 selects the source mask, 1 selects the global enable |
| wr_data_i | input | DATA_W | Write data |
| rd_i | input | 1 | Pending-register read strobe (read clears) |
| rd_data_o | output | DATA_W | Registered masked pending flags from the last read |
| irq_o | output | 1 | Registered interrupt line, active high |

## Verification
The bench builds the block with N_SRC = 8 and DATA_W = 8. At that size, random 8-bit event patterns hit every source, and random mask values reach both the all-enabled and the all-disabled extremes within a few thousand cycles.

Random reads, enable writes and events often land in the same cycle. This exercises the event-during-read case and the mask-during-pending case many times. Directed sequences pin down each of those corners with known values.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic {
    REG_SRC_MASK = 1'b0,
    REG_GLOBAL   = 1'b1
  } irqagg_reg_e;
endpackage

// File: rtl/irqagg_enables.sv
module irqagg_enables
  import irqagg_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_SRC-1:0]  eff_q_o,
  output logic [N_SRC-1:0]  eff_d_o
);
  logic [N_SRC-1:0] mask_q, mask_d;
  logic             glob_q, glob_d;

  always_comb begin
    mask_d = mask_q;
    glob_d = glob_q;
    if (wr_en_i) begin
      if (irqagg_reg_e'(wr_addr_i) == REG_SRC_MASK) mask_d = wr_data_i[N_SRC-1:0];
      else                                          glob_d = wr_data_i[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      glob_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      glob_q <= glob_d;
    end
  end

  assign eff_q_o = mask_q & {N_SRC{glob_q}};
  assign eff_d_o = mask_d & {N_SRC{glob_d}};

  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_addr_i) |=> (mask_q == $past(wr_data_i[N_SRC-1:0]))); // R10
  AST_WRITE_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i) |=> (glob_q == $past(wr_data_i[0]))); // R10
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] eff_i,
  input  logic             rd_i,
  output logic [N_SRC-1:0] pend_q_o,
  output logic [N_SRC-1:0] pend_d_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic flag_q;
    logic hit;
    assign hit         = evt_i[i] & eff_i[i];
    assign pend_d_o[i] = (flag_q & ~rd_i) | hit;
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= pend_d_o[i];
    end
    assign pend_q_o[i] = flag_q;
  end

  AST_NO_DISABLED_LATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q_o & ~$past(pend_q_o) & ~$past(evt_i & eff_i)) == '0)); // R3
  AST_ENABLED_LATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q_o & $past(evt_i & eff_i)) == $past(evt_i & eff_i))); // R2
  AST_ACCUMULATE: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> ((pend_q_o & $past(pend_q_o)) == $past(pend_q_o))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> ((pend_q_o & ~$past(evt_i & eff_i)) == '0)); // R6
endmodule

// File: rtl/irqagg_output.sv
module irqagg_output #(
  parameter int N_SRC  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [N_SRC-1:0]  pend_q_i,
  input  logic [N_SRC-1:0]  pend_d_i,
  input  logic [N_SRC-1:0]  eff_q_i,
  input  logic [N_SRC-1:0]  eff_d_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - N_SRC;

  logic [DATA_W-1:0] view;

  if (PAD_W > 0) begin : g_pad
    assign view = {{PAD_W{1'b0}}, pend_q_i & eff_q_i};
  end else begin : g_nopad
    assign view = pend_q_i & eff_q_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      irq_o <= |(pend_d_i & eff_d_i);
      if (rd_i) rd_data_o <= view;
    end
  end

  AST_RD_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o)); // R6
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] eff_q, eff_d, pend_q, pend_d;

  irqagg_enables #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_en (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .eff_q_o(eff_q), .eff_d_o(eff_d)
  );

  irqagg_pending #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .evt_i(evt_i), .eff_i(eff_q), .rd_i(rd_i),
    .pend_q_o(pend_q), .pend_d_o(pend_d)
  );

  irqagg_output #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd_i(rd_i), .pend_q_i(pend_q), .pend_d_i(pend_d),
    .eff_q_i(eff_q), .eff_d_i(eff_d), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  initial begin
    AST_WIDTH_FITS: assert (DATA_W >= N_SRC); // R10
  end

  AST_IRQ_REFLECTS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |(pend_q & eff_q))); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !rd_i && !wr_en_i) |=> irq_o); // R9
  AST_EVT_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_en_i && |(evt_i & eff_q)) |=> irq_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && rd_data_o == '0)); // R1
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int N  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  evt;
  logic          wr_en, wr_addr, rd;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [N-1:0]  m_pend, m_mask;
  logic          m_glob, m_irq;
  logic [DW-1:0] m_rd;

  always #2.5 clk = ~clk;

  irq_aggregator #(.N_SRC(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_i(rd), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [N-1:0] eff_of(logic [N-1:0] m, logic g);
    return m & {N{g}};
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] e;
    e = eff_of(m_mask, m_glob);
    if (rst) begin
      m_pend = '0; m_mask = '0; m_glob = 1'b0; m_irq = 1'b0; m_rd = '0;
    end else begin
      if (rd) m_rd = DW'(m_pend & e);
      m_pend = (rd ? '0 : m_pend) | (evt & e);
      if (wr_en) begin
        if (!wr_addr) m_mask = wr_data[N-1:0];
        else          m_glob = wr_data[0];
      end
      m_irq = |(m_pend & eff_of(m_mask, m_glob));
    end
  endtask

  // drive inputs, take one edge, update reference, sample 1 ns later
  task automatic cyc(logic [N-1:0] ev, logic we, logic wa, logic [DW-1:0] wd, logic r);
    evt = ev; wr_en = we; wr_addr = wa; wr_data = wd; rd = r;
    @(posedge clk);
    model_step();
    #1;
    evt = '0; wr_en = 1'b0; rd = 1'b0;
  endtask

  task automatic idle();
    cyc('0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #(5 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; evt = '0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd = 1'b0;
    repeat (3) cyc('0, 1'b0, 1'b0, '0, 1'b0);
    check("R1 irq in reset", DW'(irq), '0);
    check("R1 rd_data in reset", rd_data, '0);
    rst = 1'b0;
    idle();
    cyc('0, 1'b0, 1'b0, '0, 1'b1);
    check("R1 pending empty after reset", rd_data, '0);

    // R10 writes, R2/R3 latch
    cyc('0, 1'b1, 1'b0, 8'h05, 1'b0);
    cyc('0, 1'b1, 1'b1, 8'h01, 1'b0);
    check("R10 no irq after enables", DW'(irq), '0);
    cyc(8'h07, 1'b0, 1'b0, '0, 1'b0);
    check("R2 irq after enabled event", DW'(irq), 8'h01);
    repeat (4) idle();
    check("R9 irq held without read", DW'(irq), 8'h01);
    cyc('0, 1'b0, 1'b0, '0, 1'b1);
    check("R6 read data masked", rd_data, 8'h05);
    check("R6 irq low after read", DW'(irq), '0);
    // R3: source 1 event was dropped; enabling it shows nothing
    cyc('0, 1'b1, 1'b0, 8'h07, 1'b0);
    check("R3 no irq for dropped source", DW'(irq), '0);
    cyc('0, 1'b0, 1'b0, '0, 1'b1);
    check("R3 dropped source unreadable", rd_data, '0);

    // R4 global off (bit0 of 0xFE is 0)
    cyc('0, 1'b1, 1'b1, 8'hFE, 1'b0);
    cyc(8'hFF, 1'b0, 1'b0, '0, 1'b0);
    cyc('0, 1'b1, 1'b1, 8'h01, 1'b0);
    check("R4 nothing latched while global off", DW'(irq), '0);

    // R5 accumulation
    cyc(8'h01, 1'b0, 1'b0, '0, 1'b0);
    idle();
    cyc(8'h04, 1'b0, 1'b0, '0, 1'b0);
    cyc('0, 1'b0, 1'b0, '0, 1'b1);
    check("R5 accumulated flags", rd_data, 8'h05);

    // R7 event in read cycle
    cyc(8'h01, 1'b0, 1'b0, '0, 1'b0);
    cyc(8'h04, 1'b0, 1'b0, '0, 1'b1);
    check("R7 read excludes same-cycle event", rd_data, 8'h01);
    check("R7 irq stays high", DW'(irq), 8'h01);
    cyc('0, 1'b0, 1'b0, '0, 1'b1);
    check("R7 event kept for next read", rd_data, 8'h04);

    // R8 mask hides but keeps
    cyc(8'h02, 1'b0, 1'b0, '0, 1'b0);
    cyc('0, 1'b1, 1'b0, 8'h05, 1'b0);
    check("R8 irq masked", DW'(irq), '0);
    cyc('0, 1'b1, 1'b1, 8'h00, 1'b0);
    cyc('0, 1'b1, 1'b0, 8'h07, 1'b0);
    check("R8 still masked by global", DW'(irq), '0);
    cyc('0, 1'b1, 1'b1, 8'h01, 1'b0);
    check("R8 irq returns on re-enable", DW'(irq), 8'h01);
    cyc('0, 1'b0, 1'b0, '0, 1'b1);
    check("R8 flag preserved", rd_data, 8'h02);

    // random phase against reference model
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0]  ev;
      logic          we, wa, r;
      logic [DW-1:0] wd;
      ev = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      we = ($urandom_range(0, 15) == 0);
      wa = ($urandom_range(0, 3) == 0);
      wd = DW'($urandom);
      if ($urandom_range(0, 7) == 0) wd = '1;
      r  = ($urandom_range(0, 9) == 0);
      cyc(ev, we, wa, wd, r);
      check("R2 R6 random irq", DW'(irq), DW'(m_irq));
      check("R5 R7 random rd_data", rd_data, m_rd);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule